// File: doc/BRIEF.md
# Pooled Memory Slice Ownership Checker

This block sits on the access path of a multi-port pooled memory controller. Pool memory is split into fixed-size slices. For each slice the block keeps one ownership entry: a valid bit and the ID of the host that holds the slice. Every incoming memory access carries a requestor ID and a physical address. The block finds the slice that holds the address, compares the requestor with the recorded owner, and one cycle later either grants the access or raises a fatal memory error. Mismatches are never retried.

A side management port changes the table. It takes one command per cycle, either assign or release, naming a host and a slice. Assign succeeds only on an unowned slice. Release succeeds only when the named host is the current owner. Every command gets a done pulse with an error flag one cycle later. Commands and accesses run in parallel. A table change made by a command becomes visible to accesses from the following cycle onward.

Top module: `slice_own_checker`

## Requirements
- R1: The slice index is address bits `[SLICE_LSB +: log2(NUM_SLICES)]`. The defaults are SLICE_LSB=30 and NUM_SLICES=1024, giving 1 GB slices and 1 TB in total. If ADDR_W is wider than SLICE_LSB+log2(NUM_SLICES) and any address bit above the index is set, the access gets the fatal response whatever the owner is.
- R2: After reset every slice is unowned, so any access to any slice gets the fatal response.
- R3: An assign command (`mgmt_op`=0) to an unowned slice records `mgmt_host` as the owner. The command returns `mgmt_done`=1 with `mgmt_err`=0.
- R4: An assign command to a slice that is already owned returns `mgmt_err`=1 and leaves the owner unchanged.
- R5: A release command (`mgmt_op`=1) whose host matches the owner makes the slice unowned. The command returns `mgmt_err`=0.
- R6: A release command to a slice that is unowned, or whose owner differs from the named host, returns `mgmt_err`=1 and leaves the entry unchanged.
- R7: An in-range access to an owned slice whose requestor ID equals the owner gets `acc_grant`=1. Every other access gets `acc_fatal`=1. Whenever `acc_resp_valid` is 1, exactly one of the two is set.
- R8: Each access gets its response exactly one cycle after it is presented, and accesses may arrive back to back. No response appears in a cycle that follows an idle cycle.
- R9: An access presented in the same cycle as a command to the same slice is checked against the table as it was before that command. An access in the next cycle sees the command's effect.
- R10: `mgmt_done` pulses exactly one cycle after each command and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_valid | input | 1 | Management command present |
| mgmt_op | input | 1 | 0 = assign, 1 = release |
| mgmt_host | input | HOST_W | Host named by the command |
| mgmt_slice | input | log2(NUM_SLICES) | Slice named by the command |
| mgmt_done | output | 1 | Command response pulse |
| mgmt_err | output | 1 | Command rejected (valid with mgmt_done) |
| acc_valid | input | 1 | Access present |
| acc_req_id | input | HOST_W | Requestor host ID |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_resp_valid | output | 1 | Access response present |
| acc_grant | output | 1 | Access allowed |
| acc_fatal | output | 1 | Access disallowed, fatal memory error |

## Verification
Both the access result and the command status are due one clock after their inputs are presented. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which lands half a period after the register that holds the result. For back-to-back streams, each sampling point also serves as the drive point of the next access, so every response is compared in the cycle it is due. For the same-cycle case of R9, the bench presents a command and an access together and checks the old-table result first, then checks the new-table result one cycle later.

// File: rtl/slice_own_pkg.sv
// Package: shared types of the slice ownership checker.
// Assumes: nothing beyond the command encoding below.
package slice_own_pkg;
    typedef enum logic {
        OP_ASSIGN  = 1'b0,
        OP_RELEASE = 1'b1
    } own_op_e;
endpackage

// File: rtl/slice_own_table.sv
// Ownership table: one valid bit and one owner ID per slice.
// Two combinational read ports (access path, command path), one write port.
// Assumes: NUM_SLICES is a power of two; writes come only from accepted commands.
module slice_own_table #(
    parameter int NUM_SLICES = 1024,
    parameter int HOST_W     = 6,
    localparam int IDX_W     = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [HOST_W-1:0] wr_host,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic              rda_valid,
    output logic [HOST_W-1:0] rda_host,
    input  logic [IDX_W-1:0]  rdm_idx,
    output logic              rdm_valid,
    output logic [HOST_W-1:0] rdm_host
);
    logic [NUM_SLICES-1:0] valid_q;
    logic [HOST_W-1:0]     host_q [NUM_SLICES];

    // Valid bits: cleared by reset, updated by accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= wr_valid;
    end

    // Owner IDs: only meaningful while the valid bit is set, so no reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            host_q[wr_idx] <= wr_host;
    end

    // Read ports return the current stored entry.
    always_comb begin
        rda_valid = valid_q[rda_idx];
        rda_host  = host_q[rda_idx];
        rdm_valid = valid_q[rdm_idx];
        rdm_host  = host_q[rdm_idx];
    end

    // R2
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> valid_q == '0);

    // R4
    no_double_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |-> !valid_q[wr_idx]);

    // R6
    release_owned_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |-> valid_q[wr_idx]);

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] == $past(wr_valid));
endmodule

// File: rtl/slice_own_mgmt.sv
// Command unit: decides whether an assign or release is accepted,
// drives the table write, and registers the done/error response.
// Assumes: one command per cycle at most; the table read port is combinational.
module slice_own_mgmt
    import slice_own_pkg::*;
#(
    parameter int NUM_SLICES = 1024,
    parameter int HOST_W     = 6,
    localparam int IDX_W     = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_valid,
    input  own_op_e           mgmt_op,
    input  logic [HOST_W-1:0] mgmt_host,
    input  logic [IDX_W-1:0]  mgmt_slice,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic [HOST_W-1:0] rd_host,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_valid,
    output logic [HOST_W-1:0] wr_host,
    output logic              mgmt_done,
    output logic              mgmt_err
);
    logic accept;

    // Acceptance: assign needs a free slice, release needs the matching owner.
    always_comb begin
        rd_idx = mgmt_slice;
        if (mgmt_op == OP_ASSIGN)
            accept = !rd_valid;
        else
            accept = rd_valid && (rd_host == mgmt_host);
        wr_en    = mgmt_valid && accept;
        wr_idx   = mgmt_slice;
        wr_valid = (mgmt_op == OP_ASSIGN);
        wr_host  = mgmt_host;
    end

    // Response register: one-cycle done pulse with the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_done <= 1'b0;
            mgmt_err  <= 1'b0;
        end else begin
            mgmt_done <= mgmt_valid;
            mgmt_err  <= mgmt_valid && !accept;
        end
    end

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_err |-> mgmt_done);
endmodule

// File: rtl/slice_own_access.sv
// Access check: decodes the slice from the address, compares the requestor
// with the recorded owner, and registers grant or fatal one cycle later.
// Assumes: SLICE_LSB >= 1 and ADDR_W >= SLICE_LSB + log2(NUM_SLICES).
module slice_own_access #(
    parameter int NUM_SLICES = 1024,
    parameter int HOST_W     = 6,
    parameter int ADDR_W     = 40,
    parameter int SLICE_LSB  = 30,
    localparam int IDX_W     = $clog2(NUM_SLICES),
    localparam int TOP_LSB   = SLICE_LSB + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [HOST_W-1:0] acc_req_id,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic [HOST_W-1:0] rd_host,
    output logic              acc_resp_valid,
    output logic              acc_grant,
    output logic              acc_fatal
);
    logic in_range;
    logic allow;

    // Offset bits inside a slice never affect the check.
    logic unused_offset;
    assign unused_offset = ^acc_addr[SLICE_LSB-1:0];

    // Range variant: only present when the address has bits above the index.
    generate
        if (ADDR_W > TOP_LSB) begin : g_range
            assign in_range = (acc_addr[ADDR_W-1:TOP_LSB] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    // Slice decode and owner comparison.
    always_comb begin
        rd_idx = acc_addr[SLICE_LSB +: IDX_W];
        allow  = in_range && rd_valid && (rd_host == acc_req_id);
    end

    // Result register: fixed one-cycle latency, one access per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_resp_valid <= 1'b0;
            acc_grant      <= 1'b0;
            acc_fatal      <= 1'b0;
        end else begin
            acc_resp_valid <= acc_valid;
            acc_grant      <= acc_valid && allow;
            acc_fatal      <= acc_valid && !allow;
        end
    end

    // R7
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_resp_valid |-> (acc_grant ^ acc_fatal));

    // R8
    grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> $past(acc_valid));

    // R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_resp_valid |-> (!acc_grant && !acc_fatal));
endmodule

// File: rtl/slice_own_checker.sv
// Top: pooled-memory slice ownership checker. Ties the command unit and the
// access check to the shared ownership table.
// Assumes: NUM_SLICES power of two; SLICE_LSB >= 1.
module slice_own_checker
    import slice_own_pkg::*;
#(
    parameter int NUM_SLICES = 1024,
    parameter int HOST_W     = 6,
    parameter int ADDR_W     = 40,
    parameter int SLICE_LSB  = 30,
    localparam int IDX_W     = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_valid,
    input  logic              mgmt_op,
    input  logic [HOST_W-1:0] mgmt_host,
    input  logic [IDX_W-1:0]  mgmt_slice,
    output logic              mgmt_done,
    output logic              mgmt_err,
    input  logic              acc_valid,
    input  logic [HOST_W-1:0] acc_req_id,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_resp_valid,
    output logic              acc_grant,
    output logic              acc_fatal
);
    logic              wr_en, wr_valid;
    logic [IDX_W-1:0]  wr_idx, rda_idx, rdm_idx;
    logic [HOST_W-1:0] wr_host, rda_host, rdm_host;
    logic              rda_valid, rdm_valid;
    own_op_e           op_e;

    assign op_e = own_op_e'(mgmt_op);

    slice_own_table #(.NUM_SLICES(NUM_SLICES), .HOST_W(HOST_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_host(wr_host),
        .rda_idx(rda_idx), .rda_valid(rda_valid), .rda_host(rda_host),
        .rdm_idx(rdm_idx), .rdm_valid(rdm_valid), .rdm_host(rdm_host)
    );

    slice_own_mgmt #(.NUM_SLICES(NUM_SLICES), .HOST_W(HOST_W)) mgmt_i (
        .clk(clk), .rst_n(rst_n),
        .mgmt_valid(mgmt_valid), .mgmt_op(op_e), .mgmt_host(mgmt_host),
        .mgmt_slice(mgmt_slice),
        .rd_idx(rdm_idx), .rd_valid(rdm_valid), .rd_host(rdm_host),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_host(wr_host),
        .mgmt_done(mgmt_done), .mgmt_err(mgmt_err)
    );

    slice_own_access #(.NUM_SLICES(NUM_SLICES), .HOST_W(HOST_W),
                       .ADDR_W(ADDR_W), .SLICE_LSB(SLICE_LSB)) access_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_req_id(acc_req_id), .acc_addr(acc_addr),
        .rd_idx(rda_idx), .rd_valid(rda_valid), .rd_host(rda_host),
        .acc_resp_valid(acc_resp_valid), .acc_grant(acc_grant), .acc_fatal(acc_fatal)
    );
endmodule

// File: tb/slice_own_checker_tb_top.sv
// Bench: small configuration (8 slices, 4 hosts, 16-byte slices, 2 spare
// address bits), near-exhaustive sweeps against an arithmetic ownership model.
module slice_own_checker_tb_top;
    localparam int NS = 8, HW = 2, AW = 9, LSB = 4, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mgmt_valid = 0, mgmt_op = 0;
    logic [HW-1:0] mgmt_host = '0, acc_req_id = '0;
    logic [IW-1:0] mgmt_slice = '0;
    logic acc_valid = 0;
    logic [AW-1:0] acc_addr = '0;
    logic mgmt_done, mgmt_err, acc_resp_valid, acc_grant, acc_fatal;

    int checks = 0, fails = 0;
    bit m_v [NS];
    int m_h [NS];
    bit done_flag = 0;

    always #5 clk = ~clk;

    slice_own_checker #(.NUM_SLICES(NS), .HOST_W(HW), .ADDR_W(AW), .SLICE_LSB(LSB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mgmt_valid(mgmt_valid), .mgmt_op(mgmt_op), .mgmt_host(mgmt_host),
        .mgmt_slice(mgmt_slice), .mgmt_done(mgmt_done), .mgmt_err(mgmt_err),
        .acc_valid(acc_valid), .acc_req_id(acc_req_id), .acc_addr(acc_addr),
        .acc_resp_valid(acc_resp_valid), .acc_grant(acc_grant), .acc_fatal(acc_fatal)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(int top, int idx, int off);
        return AW'((top << (LSB + IW)) | (idx << LSB) | off);
    endfunction

    function automatic int exp_grant(int top, int idx, int id);
        return (top == 0 && m_v[idx] && m_h[idx] == id) ? 1 : 0;
    endfunction

    // Set up a command on the current falling edge (no clocking).
    task automatic set_cmd(int op, int host, int slice);
        mgmt_valid = 1; mgmt_op = op[0]; mgmt_host = HW'(host); mgmt_slice = IW'(slice);
    endtask

    // Issue one command, check status at the next falling edge, update the model.
    task automatic cmd(string tag, int op, int host, int slice);
        int exp_err;
        if (op == 0) exp_err = m_v[slice] ? 1 : 0;
        else exp_err = (m_v[slice] && m_h[slice] == host) ? 0 : 1;
        set_cmd(op, host, slice);
        @(negedge clk);
        mgmt_valid = 0;
        chk({tag, " done"}, int'(mgmt_done), 1);
        chk({tag, " err"}, int'(mgmt_err), exp_err);
        if (exp_err == 0) begin
            m_v[slice] = (op == 0);
            m_h[slice] = host;
        end
    endtask

    // Issue one access and check its response one cycle later.
    task automatic acc(string tag, int id, int top, int idx, int off);
        int g;
        g = exp_grant(top, idx, id);
        acc_valid = 1; acc_req_id = HW'(id); acc_addr = mk_addr(top, idx, off);
        @(negedge clk);
        acc_valid = 0;
        chk({tag, " valid"}, int'(acc_resp_valid), 1);
        chk({tag, " grant"}, int'(acc_grant), g);
        chk({tag, " fatal"}, int'(acc_fatal), 1 - g);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_h[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 R8 reset state: no responses
        chk("R10 idle done", int'(mgmt_done), 0);
        chk("R8 idle resp", int'(acc_resp_valid), 0);

        // R2: every slice, every host, fatal after reset
        for (int s = 0; s < NS; s++)
            for (int h = 0; h < 4; h++) acc("R2 unowned", h, 0, s, (s + h) % 16);

        // R3: assign slice s to host s%4
        for (int s = 0; s < NS; s++) cmd("R3 assign", 0, s % 4, s);
        // R10: no done pulse after idle cycle
        @(negedge clk);
        chk("R10 no cmd", int'(mgmt_done), 0);

        // R4: re-assign to another host rejected, owner kept
        for (int s = 0; s < NS; s++) cmd("R4 reassign", 0, (s + 1) % 4, s);

        // R7 R1: full sweep slice x host x offset pattern
        for (int s = 0; s < NS; s++)
            for (int h = 0; h < 4; h++) acc("R7 sweep", h, 0, s, (s * 5 + h * 3) % 16);
        // R1: out-of-range upper bits fatal even for owner
        for (int t = 1; t < 4; t++)
            for (int s = 0; s < NS; s += 3) acc("R1 range", s % 4, t, s, 0);

        // R6: release by wrong host rejected
        for (int s = 0; s < NS; s++) cmd("R6 wrong rel", 1, (s + 2) % 4, s);
        acc("R6 kept", 1, 0, 1, 9);
        // R5: release by owner for even slices, then again -> R6
        for (int s = 0; s < NS; s += 2) cmd("R5 release", 1, s % 4, s);
        for (int s = 0; s < NS; s += 2) cmd("R6 re-release", 1, s % 4, s);
        for (int s = 0; s < NS; s++) acc("R5 after", s % 4, 0, s, 1);

        // R8: back-to-back stream, response due each following cycle
        for (int k = 0; k < 16; k++) begin
            int s = k % NS, h = (k * 3) % 4;
            int g = exp_grant(0, s, h);
            acc_valid = 1; acc_req_id = HW'(h); acc_addr = mk_addr(0, s, k);
            @(negedge clk);
            chk("R8 stream valid", int'(acc_resp_valid), 1);
            chk("R8 stream grant", int'(acc_grant), g);
        end
        acc_valid = 0;
        @(negedge clk);
        chk("R8 gap", int'(acc_resp_valid), 0);

        // R9: assign slice 0 to host 3 with same-cycle access by host 3
        set_cmd(0, 3, 0);
        acc_valid = 1; acc_req_id = 2'd3; acc_addr = mk_addr(0, 0, 0);
        @(negedge clk);
        mgmt_valid = 0;
        chk("R9 cmd ok", int'(mgmt_err), 0);
        chk("R9 old table", int'(acc_fatal), 1);
        m_v[0] = 1; m_h[0] = 3;
        @(negedge clk);
        acc_valid = 0;
        chk("R9 new table", int'(acc_grant), 1);
        // R9: release same cycle as access -> still granted, then fatal
        set_cmd(1, 3, 0);
        acc_valid = 1;
        @(negedge clk);
        mgmt_valid = 0;
        chk("R9 rel old", int'(acc_grant), 1);
        m_v[0] = 0;
        @(negedge clk);
        acc_valid = 0;
        chk("R9 rel new", int'(acc_fatal), 1);

        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule